// File: doc/BRIEF.md
# Divider and Programmable Timer Unit

This peripheral keeps time for a processor core. A one-cycle `tick` strobe marks each machine cycle. From that strobe the unit drives a free-running 8-bit divider, which steps once every 64 ticks through a hidden prescaler. It also drives an 8-bit timer counter whose rate is programmable. When the counter rolls over, it reloads from a modulo register and raises a single-clock interrupt request.

Software reaches the unit through a small register bus with four addresses: 0 for the divider, 1 for the counter, 2 for the modulo register and 3 for the control register. A write is a one-cycle `wr_en` pulse with `addr` and `wdata`. Reads are combinational from `addr`. Any write to the divider clears it and restarts its hidden prescaler.

Top module: `tick_timer`

## Requirements
- R1: After the synchronous active-high reset, the divider, the counter and the modulo register read 0x00. The control register reads 0xF8, and `irq_timer` is low.
- R2: The divider steps by one on every 64th tick and wraps from 0xFF to 0x00. It does not change in cycles without a tick or a divider write.
- R3: A write to address 0 sets the divider to 0x00, whatever the data. It also restarts the hidden prescaler at 1, so the next step comes 63 ticks later. The first step after reset also comes after 63 ticks.
- R4: The counter advances only while control bit 2 is 1. While that bit is 0, the timer prescaler keeps its partial count, and counting later resumes from it.
- R5: Control bits [1:0] set the ticks per counter step: 00 gives 256, 01 gives 4, 10 gives 16, and 11 gives 64.
- R6: A step of the counter from 0xFF loads it with the modulo register value at the same clock edge.
- R7: `irq_timer` is high for exactly one clock, starting at the edge that reloads the counter after an overflow. At all other times it is low.
- R8: Reads return the divider at address 0, the counter at 1 and the modulo register at 2. At 3 they return the control value with bits [7:3] forced to 1.
- R9: A write to address 1 loads the counter with the data. If a counter step falls on the same edge, the write takes priority.
- R10: If a divider write and a tick fall on the same edge, the write takes priority. The prescaler restarts at 1 and ignores that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle machine-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| irq_timer | output | 1 | Timer overflow interrupt pulse |

## Verification
Register writes, divider steps and counter steps show up at the clock edge that samples the strobe. Reads are combinational, so each check puts `addr` on the bus and samples `rdata` in the negedge phase that follows that edge. The interrupt comes from a register and rises at the same edge that reloads the counter, so the bench samples it just after that edge. It samples again one cycle later to confirm the pulse has dropped. Each scenario counts ticks exactly to the expected boundary: it checks one tick before the step, where the old value must remain, and then right after the step.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int PRE_W = 9;

  typedef enum logic [1:0] {
    SEL_DIV = 2'd0,
    SEL_CNT = 2'd1,
    SEL_MOD = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  // ticks per counter step for each rate code
  function automatic logic [PRE_W-1:0] rate_period(input logic [1:0] code);
    case (code)
      2'b00:   return PRE_W'(256);
      2'b01:   return PRE_W'(4);
      2'b10:   return PRE_W'(16);
      default: return PRE_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/div_chain.sv
module div_chain #(
  parameter int W       = 8,
  parameter int PERIOD  = 64,
  parameter int RESTART = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clear,
  output logic [W-1:0] value,
  output logic         step
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] pre_q;
  logic [W-1:0]  val_q;

  assign step  = tick && !clear && (pre_q == PW'(PERIOD - 1));
  assign value = val_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= PW'(RESTART);
      val_q <= '0;
    end else if (tick) begin
      if (step) begin
        pre_q <= '0;
        val_q <= val_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rate_timer.sv
module rate_timer
  import tick_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         enable,
  input  logic [1:0]   rate_sel,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic [W-1:0] modulo,
  output logic [W-1:0] count,
  output logic         bump,
  output logic         ovf,
  output logic         irq
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_nx;
  logic [PRE_W-1:0] period;
  logic [W-1:0]     cnt_q;
  logic             irq_q;

  assign period = rate_period(rate_sel);
  assign pre_nx = pre_q + 1'b1;
  assign bump   = tick && enable && (pre_nx >= period);
  assign ovf    = bump && (cnt_q == '1);
  assign count  = cnt_q;
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ovf;
      if (tick && enable)
        pre_q <= bump ? (pre_nx - period) : pre_nx;
      if (cnt_wr)
        cnt_q <= cnt_wdata;
      else if (ovf)
        cnt_q <= modulo;
      else if (bump)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int W          = 8,
  parameter int DIV_PERIOD = 64,
  parameter int DIV_START  = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq_timer
);
  localparam int CTL_W = 3;

  logic [W-1:0]     div_val;
  logic             div_step;
  logic             div_wr;
  logic             cnt_wr;
  logic [W-1:0]     mod_q;
  logic [CTL_W-1:0] ctl_q;
  logic [W-1:0]     cnt_val;
  logic             cnt_bump;
  logic             cnt_ovf;
  logic             timer_on;

  assign div_wr   = wr_en && (addr == SEL_DIV);
  assign cnt_wr   = wr_en && (addr == SEL_CNT);
  assign timer_on = ctl_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (addr == SEL_MOD) mod_q <= wdata;
      if (addr == SEL_CTL) ctl_q <= wdata[CTL_W-1:0];
    end
  end

  div_chain #(.W(W), .PERIOD(DIV_PERIOD), .RESTART(DIV_START)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .clear(div_wr),
    .value(div_val), .step(div_step)
  );

  rate_timer #(.W(W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .enable(timer_on),
    .rate_sel(ctl_q[1:0]), .cnt_wr(cnt_wr), .cnt_wdata(wdata),
    .modulo(mod_q), .count(cnt_val), .bump(cnt_bump),
    .ovf(cnt_ovf), .irq(irq_timer)
  );

  always_comb begin
    case (addr)
      SEL_DIV: rdata = div_val;
      SEL_CNT: rdata = cnt_val;
      SEL_MOD: rdata = mod_q;
      default: rdata = {{(W-CTL_W){1'b1}}, ctl_q};
    endcase
  end
endmodule

// File: rtl/tick_timer_checks.sv
module tick_timer_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] div_value,
  input logic         div_step,
  input logic [W-1:0] cnt_value,
  input logic         cnt_ovf,
  input logic [W-1:0] mod_value,
  input logic         timer_on,
  input logic         irq
);
  p_div_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> (div_value == '0));

  p_div_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && addr == 2'd0)) |=> $stable(div_value));

  p_div_step_r2: assert property (@(posedge clk) disable iff (rst)
    div_step |=> (div_value == W'($past(div_value) + 1'b1)));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!timer_on && !(wr_en && addr == 2'd1)) |=> $stable(cnt_value));

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_ovf && !(wr_en && addr == 2'd1)) |=> (cnt_value == $past(mod_value)));

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf |=> irq);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cnt_ovf |=> !irq);

  p_cnt_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1) |=> (cnt_value == $past(wdata)));
endmodule

bind tick_timer tick_timer_checks #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .div_value(div_val), .div_step(div_step),
  .cnt_value(cnt_val), .cnt_ovf(cnt_ovf), .mod_value(mod_q),
  .timer_on(timer_on), .irq(irq_timer)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_timer;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_timer(irq_timer)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 divider", v, 8'h00);
    rd(2'd1, v); chk("R1 counter", v, 8'h00);
    rd(2'd2, v); chk("R1 modulo", v, 8'h00);
    rd(2'd3, v); chk("R1 control R8", v, 8'hF8);
    chk("R1 irq", {7'd0, irq_timer}, 8'h00);
  endtask

  task automatic t_divider;
    logic [7:0] v;
    ticks(62); rd(2'd0, v); chk("R3 first step not early", v, 8'h00);
    ticks(1);  rd(2'd0, v); chk("R3 first step after 63", v, 8'h01);
    ticks(64); rd(2'd0, v); chk("R2 step every 64", v, 8'h02);
    repeat (100) @(negedge clk);
    rd(2'd0, v); chk("R2 no change without tick", v, 8'h02);
    ticks(30);
    wr(2'd0, 8'hA5); rd(2'd0, v); chk("R3 write clears", v, 8'h00);
    ticks(62); rd(2'd0, v); chk("R3 restart at 1, early", v, 8'h00);
    ticks(1);  rd(2'd0, v); chk("R3 restart at 1, step", v, 8'h01);
    ticks(64 * 254); rd(2'd0, v); chk("R2 reach top", v, 8'hFF);
    ticks(64); rd(2'd0, v); chk("R2 wrap", v, 8'h00);
  endtask

  task automatic t_div_collide;
    logic [7:0] v;
    ticks(100);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h3C;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(2'd0, v); chk("R10 write wins", v, 8'h00);
    ticks(62); rd(2'd0, v); chk("R10 tick ignored, early", v, 8'h00);
    ticks(1);  rd(2'd0, v); chk("R10 tick ignored, step", v, 8'h01);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R8 control readback", v, 8'hF9);
    ticks(20); rd(2'd1, v); chk("R4 disabled no count", v, 8'h00);
    wr(2'd3, 8'h05);
    ticks(3); rd(2'd1, v); chk("R5 rate 01 early", v, 8'h00);
    ticks(1); rd(2'd1, v); chk("R5 rate 01 step", v, 8'h01);
    ticks(3);
    wr(2'd3, 8'h01);
    ticks(10); rd(2'd1, v); chk("R4 hold while off", v, 8'h01);
    wr(2'd3, 8'h05);
    ticks(1); rd(2'd1, v); chk("R4 prescaler kept", v, 8'h02);
  endtask

  task automatic t_rates;
    logic [7:0] v;
    wr(2'd3, 8'h06);
    ticks(15); rd(2'd1, v); chk("R5 rate 10 early", v, 8'h02);
    ticks(1);  rd(2'd1, v); chk("R5 rate 10 step", v, 8'h03);
    wr(2'd3, 8'h07);
    ticks(63); rd(2'd1, v); chk("R5 rate 11 early", v, 8'h03);
    ticks(1);  rd(2'd1, v); chk("R5 rate 11 step", v, 8'h04);
    wr(2'd3, 8'h04);
    ticks(255); rd(2'd1, v); chk("R5 rate 00 early", v, 8'h04);
    ticks(1);   rd(2'd1, v); chk("R5 rate 00 step", v, 8'h05);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    wr(2'd2, 8'hC0);
    rd(2'd2, v); chk("R8 modulo readback", v, 8'hC0);
    wr(2'd1, 8'hFE);
    wr(2'd3, 8'h05);
    ticks(4); rd(2'd1, v); chk("R6 reach FF", v, 8'hFF);
    chk("R7 no irq before overflow", {7'd0, irq_timer}, 8'h00);
    ticks(3);
    chk("R7 no irq mid period", {7'd0, irq_timer}, 8'h00);
    ticks(1);
    rd(2'd1, v); chk("R6 reload from modulo", v, 8'hC0);
    chk("R7 irq high", {7'd0, irq_timer}, 8'h01);
    @(negedge clk);
    chk("R7 irq one clock", {7'd0, irq_timer}, 8'h00);
  endtask

  task automatic t_cnt_write;
    logic [7:0] v;
    ticks(3);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'h80;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(2'd1, v); chk("R9 write beats step", v, 8'h80);
    ticks(4); rd(2'd1, v); chk("R9 counts on from write", v, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_divider();
    t_div_collide();
    t_enable();
    t_rates();
    t_overflow();
    t_cnt_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule